// File: doc/BRIEF.md
# Replicated Round-Robin Bus Arbiter

This block decides which master owns a shared bus that is wired through every chip of a stack. Each chip carries an identical copy. Every copy sees the same master request lines, the same slave request and slave status lines, and the same lock flag, and computes the same grant on the same clock edge. No grant wires run between chips and no central arbiter exists. Each copy also reports whether the winner is its own chip, using a local chip ID.

Arbitration happens in the request stage of a three-stage bus pipeline. A grant decided from the inputs of cycle t appears on the outputs in cycle t+1, which is the address/command stage of that transfer. The lock flag is sampled during that stage. A new grant may be issued in every cycle, so transfers overlap back to back.

The controller has three states. OPEN means no transfer is in its address stage and the bus is not locked. ISSUED means a grant was issued on the last edge. LOCKED means the owner holds the bus. The transitions are as follows. In OPEN, bus_lock is ignored and a round-robin winner moves the controller to ISSUED. Without a winner it stays in OPEN. In ISSUED or LOCKED with bus_lock high, only the owner can be granted and the next state is LOCKED. In ISSUED or LOCKED with bus_lock low, the controller arbitrates by round robin and goes to ISSUED on a winner or to OPEN without one.

Top module: `stack_bus_arbiter`

## Requirements
- R1: After reset no grant is shown (grant_oh zero, grant_any and local_grant low, grant_idx zero), the state is OPEN, and the round-robin pointer is 0, so with all masters requesting the first grant goes to master 0.
- R2: Each grant is registered one cycle after the inputs that caused it, grant_oh is zero or one-hot, and a granted master had its request bit high in the deciding cycle.
- R3: Outside a lock, the winner is the first eligible master at or after the pointer, searching upward and wrapping from the highest index to 0. After each such grant the pointer becomes winner+1, wrapping to 0.
- R4: Each master names a target slave in its 4-bit field of mdest (master i uses bits 4i+3..4i). A master whose target slave has sbusy bit = 1 is not eligible that cycle, and other masters may win instead.
- R5: While any bit of sreq is 1, no master is granted in that cycle.
- R6: If bus_lock is 1 while the state is ISSUED or LOCKED, only the current owner can be granted. It is granted when eligible, otherwise no grant is issued, and the pointer does not move.
- R7: When bus_lock is 0 in the LOCKED state, round robin resumes in that same cycle, starting at owner+1.
- R8: bus_lock has no effect in the OPEN state: the grant follows round robin as if the lock were low.
- R9: local_grant is 1 exactly when a grant is shown and grant_idx equals the chip_id presented in the deciding cycle.
- R10: Grants can be issued in consecutive cycles with no idle cycle between them.
- R11: grant_any equals the OR of grant_oh, and grant_idx is the binary position of the set bit of grant_oh (0 when there is no grant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous bus reset |
| chip_id | input | 4 | This chip's position in the stack |
| mreq | input | 16 | Master request lines |
| mdest | input | 64 | Target slave of each master, 4 bits per master |
| sreq | input | 16 | Slave request lines; any high stalls master grants |
| sbusy | input | 16 | Slave status lines, 1 = busy |
| bus_lock | input | 1 | Lock flag, sampled while a grant is in its address stage or while locked |
| grant_oh | output | 16 | One-hot grant vector |
| grant_any | output | 1 | A grant is shown this cycle |
| grant_idx | output | 4 | Index of the granted master |
| local_grant | output | 1 | The granted master is this chip |

## Verification
Every cycle, the assertions check that the grant is one-hot and matches its index and any-flag, that a granted master was requesting, that slave requests stall grants, that the local flag follows the chip ID, and that every grant made while locked goes to the owner. Only the bench scenarios can show the fairness order and its wrap-around, skipping of masters whose target slave is busy, the pointer staying frozen across a lock and resuming at owner+1, lock being ignored in OPEN, and grants issued back to back. A reference model in the bench follows these rules from the requirements and predicts each registered grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ARB_OPEN   = 2'd0,
        ARB_ISSUED = 2'd1,
        ARB_LOCKED = 2'd2
    } arb_state_e;

    // Index one past idx, wrapping to zero at n.
    function automatic int wrap_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/arb_eligible.sv
module arb_eligible #(
    parameter int NUM_MASTERS = 16,
    parameter int NUM_SLAVES  = 16,
    localparam int SIDX_W     = $clog2(NUM_SLAVES)
) (
    input  logic [NUM_MASTERS-1:0]        mreq,
    input  logic [NUM_MASTERS*SIDX_W-1:0] mdest,
    input  logic [NUM_SLAVES-1:0]         sreq,
    input  logic [NUM_SLAVES-1:0]         sbusy,
    output logic [NUM_MASTERS-1:0]        eligible
);

    logic slave_stall;
    assign slave_stall = |sreq;

    for (genvar gi = 0; gi < NUM_MASTERS; gi++) begin : g_master
        logic [SIDX_W-1:0] target;
        assign target       = mdest[gi*SIDX_W +: SIDX_W];
        assign eligible[gi] = mreq[gi] & ~sbusy[target] & ~slave_stall;
    end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NUM_MASTERS = 16,
    localparam int MIDX_W     = $clog2(NUM_MASTERS)
) (
    input  logic [NUM_MASTERS-1:0] eligible,
    input  logic [MIDX_W-1:0]      start,
    output logic                   found,
    output logic [MIDX_W-1:0]      idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < NUM_MASTERS; k++) begin
            int cand;
            cand = int'(start) + k;
            if (cand >= NUM_MASTERS) cand = cand - NUM_MASTERS;
            if (!found && eligible[cand]) begin
                found = 1'b1;
                idx   = MIDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/stack_bus_arbiter.sv
module stack_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 16,
    parameter int NUM_SLAVES  = 16,
    localparam int MIDX_W     = $clog2(NUM_MASTERS),
    localparam int SIDX_W     = $clog2(NUM_SLAVES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [MIDX_W-1:0]             chip_id,
    input  logic [NUM_MASTERS-1:0]        mreq,
    input  logic [NUM_MASTERS*SIDX_W-1:0] mdest,
    input  logic [NUM_SLAVES-1:0]         sreq,
    input  logic [NUM_SLAVES-1:0]         sbusy,
    input  logic                          bus_lock,
    output logic [NUM_MASTERS-1:0]        grant_oh,
    output logic                          grant_any,
    output logic [MIDX_W-1:0]             grant_idx,
    output logic                          local_grant
);

    arb_state_e          state_q, state_d;
    logic [MIDX_W-1:0]   ptr_q, ptr_d;
    logic [MIDX_W-1:0]   owner_q, owner_d;
    logic [NUM_MASTERS-1:0] eligible;
    logic                pick_found;
    logic [MIDX_W-1:0]   pick_idx;
    logic                lock_path;
    logic                win;
    logic [MIDX_W-1:0]   win_idx;

    arb_eligible #(
        .NUM_MASTERS (NUM_MASTERS),
        .NUM_SLAVES  (NUM_SLAVES)
    ) u_elig (
        .mreq     (mreq),
        .mdest    (mdest),
        .sreq     (sreq),
        .sbusy    (sbusy),
        .eligible (eligible)
    );

    arb_rr_pick #(
        .NUM_MASTERS (NUM_MASTERS)
    ) u_pick (
        .eligible (eligible),
        .start    (ptr_q),
        .found    (pick_found),
        .idx      (pick_idx)
    );

    // Decision and next state
    always_comb begin
        lock_path = 1'b0;
        unique case (state_q)
            ARB_OPEN:   lock_path = 1'b0;
            ARB_ISSUED: lock_path = bus_lock;
            ARB_LOCKED: lock_path = bus_lock;
            default:    lock_path = 1'b0;
        endcase

        state_d = state_q;
        ptr_d   = ptr_q;
        owner_d = owner_q;
        if (lock_path) begin
            win     = eligible[owner_q];
            win_idx = owner_q;
            state_d = ARB_LOCKED;
        end else begin
            win     = pick_found;
            win_idx = pick_idx;
            if (pick_found) begin
                state_d = ARB_ISSUED;
                ptr_d   = MIDX_W'(wrap_next(int'(pick_idx), NUM_MASTERS));
                owner_d = pick_idx;
            end else begin
                state_d = ARB_OPEN;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_OPEN;
            ptr_q   <= '0;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            owner_q <= owner_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_oh    <= '0;
            grant_any   <= 1'b0;
            grant_idx   <= '0;
            local_grant <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_MASTERS; i++) begin
                grant_oh[i] <= win && (win_idx == MIDX_W'(i));
            end
            grant_any   <= win;
            grant_idx   <= win ? win_idx : '0;
            local_grant <= win && (win_idx == chip_id);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh)); // R2
    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |-> (($past(mreq) & grant_oh) != '0)); // R2
    AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any == (grant_oh != '0)); // R11
    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |-> grant_oh[grant_idx]); // R11
    AST_SLAVE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|sreq) |-> !grant_any); // R5
    AST_LOCAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        local_grant == (grant_any && grant_idx == $past(chip_id))); // R9
    AST_LOCK_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_LOCKED && grant_any) |-> grant_idx == owner_q); // R6

endmodule

// File: tb/stack_bus_arbiter_tb.sv
module stack_bus_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  chip_id;
    logic [15:0] mreq;
    logic [63:0] mdest;
    logic [15:0] sreq;
    logic [15:0] sbusy;
    logic        bus_lock;
    logic [15:0] grant_oh;
    logic        grant_any;
    logic [3:0]  grant_idx;
    logic        local_grant;

    always #2.5 clk = ~clk;

    stack_bus_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .mreq(mreq),
        .mdest(mdest), .sreq(sreq), .sbusy(sbusy), .bus_lock(bus_lock),
        .grant_oh(grant_oh), .grant_any(grant_any), .grant_idx(grant_idx),
        .local_grant(local_grant)
    );

    typedef struct {
        logic [15:0] oh;
        logic        any;
        logic [3:0]  idx;
        logic        loc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   fails = 0;
    bit   done  = 0;
    int   dest_v[16];

    // Reference model state: 0 open, 1 issued, 2 locked
    int m_state, m_ptr, m_owner;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] rq, input logic [15:0] bz,
                        input logic [15:0] srq, input logic lk, input string tag);
        logic [15:0] el;
        exp_t e;
        bit w;
        int wi;
        @(negedge clk);
        mreq = rq; sbusy = bz; sreq = srq; bus_lock = lk;
        for (int i = 0; i < 16; i++) mdest[i*4 +: 4] = 4'(dest_v[i]);
        for (int i = 0; i < 16; i++) el[i] = rq[i] && !bz[dest_v[i]] && (srq == 0);
        w = 0; wi = 0;
        if (m_state != 0 && lk) begin
            w = el[m_owner]; wi = m_owner; m_state = 2;
        end else begin
            for (int k = 0; k < 16; k++) begin
                int c;
                c = (m_ptr + k) % 16;
                if (!w && el[c]) begin w = 1; wi = c; end
            end
            if (w) begin m_state = 1; m_ptr = (wi + 1) % 16; m_owner = wi; end
            else m_state = 0;
        end
        e.oh  = w ? (16'h1 << wi) : 16'h0;
        e.any = w;
        e.idx = w ? 4'(wi) : 4'h0;
        e.loc = w && (4'(wi) == chip_id);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops expected items after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(grant_oh == e.oh, e.tag, "grant_oh", int'(grant_oh), int'(e.oh));
                check(grant_any == e.any, e.tag, "grant_any", int'(grant_any), int'(e.any));
                check(grant_idx == e.idx, e.tag, "grant_idx", int'(grant_idx), int'(e.idx));
                check(local_grant == e.loc, e.tag, "local_grant", int'(local_grant), int'(e.loc));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 0; chip_id = 4'd3; mreq = 0; sreq = 0; sbusy = 0; bus_lock = 0;
        mdest = 0;
        for (int i = 0; i < 16; i++) dest_v[i] = i;
        m_state = 0; m_ptr = 0; m_owner = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state at the ports
        check(grant_oh == 0 && !grant_any && grant_idx == 0 && !local_grant,
              "R1", "reset outputs", int'(grant_oh), 0);

        // R1 first grant goes to master 0; R3 R10 back-to-back full rotation with wrap
        for (int i = 0; i < 18; i++) step(16'hFFFF, 0, 0, 0, "R1,R3,R10");
        step(16'h0000, 0, 0, 0, "R2");
        // R3 sparse requests and wrap-around
        step(16'h8004, 0, 0, 0, "R3");
        step(16'h8004, 0, 0, 0, "R3");
        step(16'h8004, 0, 0, 0, "R3");
        step(16'h0110, 0, 0, 0, "R3,R11");
        // R4 busy target slave skips the master
        dest_v[5] = 9; dest_v[6] = 9; dest_v[7] = 2;
        step(16'h00E0, 16'h0200, 0, 0, "R4");
        step(16'h00E0, 16'h0200, 0, 0, "R4");
        step(16'h00E0, 16'h0000, 0, 0, "R4");
        step(16'h0060, 16'h0204, 0, 0, "R4");
        // R5 slave request stalls all master grants
        step(16'hFFFF, 0, 16'h0010, 0, "R5");
        step(16'hFFFF, 0, 16'h8000, 0, "R5");
        step(16'hFFFF, 0, 0, 0, "R5");
        // R6 lock keeps the owner; R7 release resumes at owner+1
        step(16'hFFFF, 0, 0, 0, "R6");
        step(16'hFFFF, 0, 0, 1, "R6");
        step(16'hFFFF, 0, 0, 1, "R6");
        step(16'hFFFF & ~(16'h1 << m_owner), 0, 0, 1, "R6");
        step(16'hFFFF, 0, 0, 1, "R6");
        step(16'hFFFF, 0, 0, 0, "R7");
        step(16'hFFFF, 0, 0, 0, "R7");
        // R8 lock ignored in OPEN
        step(16'h0000, 0, 0, 0, "R8");
        step(16'h0000, 0, 0, 1, "R8");
        step(16'h0030, 0, 0, 1, "R8");
        step(16'h0030, 0, 0, 0, "R8");
        // R9 local grant follows chip_id
        chip_id = 4'd9;
        for (int i = 0; i < 4; i++) step(16'h0A00, 0, 0, 0, "R9,R11");
        chip_id = 4'd0;
        step(16'h0001, 0, 0, 0, "R9");
        step(16'h0000, 0, 0, 0, "R9");
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule